// File: doc/BRIEF.md
# Real-to-Complex Quarter-Rate Halfband Decimator

This block turns a stream of real signed samples arriving at rate fs into complex I/Q samples at fs/2. The output matches what a quarter-rate complex downmix followed by a halfband decimate-by-two filter would give. There is no mixer in the datapath. The quarter-rate rotation reduces to two cheap steps: the even-branch coefficients are sign-flipped on alternate taps when they are written, and every output has a sign toggle applied. The in-phase output is the sign-adjusted even polyphase branch. The quadrature output is a single delayed odd-indexed sample shifted right by one, which is the centre tap of value one half.

Input samples are numbered x[0], x[1], ... from reset, counting only cycles with the input valid high. Sample x[n] is taken as zero for n < 0. The even-indexed samples feed the filter branch and the odd-indexed samples feed the quadrature delay. Output m is produced once x[2m+1] has been accepted. A downstream tuning oscillator or resampler would consume this output, and loads the even-branch taps through the write port.

Top module: `qr_halfband_decim`

## Requirements
- R1: Exactly one output is produced per two accepted input samples. `iq_vld` is high for one cycle, on the cycle after x[2m+1] is accepted, and is never high on two consecutive cycles.
- R2: Before the sign toggle, I of output m is the rounded value of S = sum over k = 0..NTAP-1 of c'[k]·x[2m−2k]. Here c'[k] is the stored form of tap k, and the coefficients are fractional with 17 fraction bits.
- R3: A write of value v to tap address k stores (−1)^k·v. Odd-address taps are negated at load time and keep full range, so −131072 is stored as +131072. Writes to addresses ≥ NTAP have no effect.
- R4: Before the sign toggle, Q of output m is x[2m−17] shifted right arithmetically by one bit. This uses only odd-indexed input samples.
- R5: Both I and Q of output m are multiplied by (−1)^m. The first output after reset is not negated.
- R6: I is formed in three steps. First round half up: (S + 2^16) >>> 17. Then apply the R5 sign. Then saturate to the range −32768..32767.
- R7: Reset clears the output valid, both outputs, all sample history, all stored taps and the sign toggle.
- R8: Cycles with the input valid low change nothing. The output values hold between results, and the results do not depend on gaps between input samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Input sample valid |
| smp_data | input | DW | Real input sample, signed |
| tap_we | input | 1 | Coefficient write strobe |
| tap_addr | input | $clog2(NTAP) | Even-branch tap index |
| tap_data | input | CW | Coefficient value, signed, 17 fraction bits |
| iq_vld | output | 1 | Output sample valid |
| iq_i | output | DW | In-phase output, signed |
| iq_q | output | DW | Quadrature output, signed |

## Verification
The bench drives single impulses at even and odd positions, so that each tap's sign and the quadrature delay appear directly at the outputs. A coefficient stored without the alternate negation, or a delay off by one sample pair, would give wrong signs or shifted responses. Full-scale inputs with maximum taps, including the most negative tap value on odd addresses, exercise saturation after the sign toggle. A design that saturated before negating, or that stored the negated coefficient in 18 bits, would wrap. A reset in the middle of a stream shows whether the sign toggle restarts at positive. Long random streams with random idle gaps show whether idle cycles corrupt the pairing of even and odd samples.

// File: rtl/qhb_pkg.sv
package qhb_pkg;
    // which sample of the incoming pair is expected next
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;
endpackage

// File: rtl/qhb_coef_bank.sv
module qhb_coef_bank #(
    parameter int NTAP = 19,
    parameter int CW   = 18,
    localparam int TAW = $clog2(NTAP),
    localparam int CSW = CW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [TAW-1:0]        addr,
    input  logic [CW-1:0]         wdata,
    output logic [NTAP*CSW-1:0]   coef_flat
);
    logic signed [CSW-1:0] wext;
    assign wext = {wdata[CW-1], wdata};

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        logic signed [CSW-1:0] tap_d, tap_q;
        always_comb begin
            tap_d = tap_q;
            if (we && addr == TAW'(k)) begin
                // quarter-rate rotation folded in: odd taps negated once here
                tap_d = (k % 2 == 1) ? -wext : wext;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) tap_q <= '0;
            else     tap_q <= tap_d;
        end
        assign coef_flat[k*CSW +: CSW] = tap_q;
    end
endmodule

// File: rtl/qhb_delay_line.sv
module qhb_delay_line #(
    parameter int DEPTH = 9,
    parameter int DW    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic [DW-1:0]         din,
    output logic [DEPTH*DW-1:0]   taps_flat
);
    logic [DW-1:0] line_d [DEPTH];
    logic [DW-1:0] line_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) line_d[i] = line_q[i];
        if (shift_en) begin
            line_d[0] = din;
            for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) line_q[i] <= '0;
            else     line_q[i] <= line_d[i];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign taps_flat[i*DW +: DW] = line_q[i];
    end
endmodule

// File: rtl/qhb_even_mac.sv
module qhb_even_mac #(
    parameter int NTAP = 19,
    parameter int DW   = 16,
    parameter int CSW  = 19,
    parameter int AW   = 41,
    localparam int PW  = DW + CSW
) (
    input  logic [NTAP*DW-1:0]    smp_flat,
    input  logic [NTAP*CSW-1:0]   coef_flat,
    output logic signed [AW-1:0]  acc
);
    logic signed [PW-1:0] prod [NTAP];

    for (genvar k = 0; k < NTAP; k++) begin : g_mul
        logic signed [PW-1:0] s_ext;
        logic signed [PW-1:0] c_ext;
        assign s_ext = {{(PW-DW){smp_flat[k*DW+DW-1]}}, smp_flat[k*DW +: DW]};
        assign c_ext = {{(PW-CSW){coef_flat[k*CSW+CSW-1]}}, coef_flat[k*CSW +: CSW]};
        assign prod[k] = s_ext * c_ext;
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++) begin
            acc = acc + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
        end
    end
endmodule

// File: rtl/qr_halfband_decim.sv
module qr_halfband_decim #(
    parameter int NTAP = 19,
    parameter int DW   = 16,
    parameter int CW   = 18,
    localparam int TAW = $clog2(NTAP)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           smp_vld,
    input  logic [DW-1:0]  smp_data,
    input  logic           tap_we,
    input  logic [TAW-1:0] tap_addr,
    input  logic [CW-1:0]  tap_data,
    output logic           iq_vld,
    output logic [DW-1:0]  iq_i,
    output logic [DW-1:0]  iq_q
);
    import qhb_pkg::*;

    localparam int HALF = NTAP / 2;
    localparam int CSW  = CW + 1;
    localparam int FRAC = CW - 1;
    localparam int AW   = DW + CSW + $clog2(NTAP) + 1;
    localparam logic signed [AW-1:0] RND_ADD = {{(AW-1){1'b0}}, 1'b1} << (FRAC - 1);
    localparam logic signed [AW-1:0] SAT_HI  = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_LO  = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    typedef struct packed {
        phase_e        ph;
        logic          neg;
        logic          vld;
        logic [DW-1:0] i;
        logic [DW-1:0] q;
    } st_t;

    st_t st_d, st_q;

    logic                  even_en, odd_en;
    logic [NTAP*DW-1:0]    even_flat;
    logic [HALF*DW-1:0]    odd_flat;
    logic [NTAP*CSW-1:0]   coef_flat;
    logic signed [AW-1:0]  acc;
    logic signed [AW-1:0]  rnd, signed_rnd;
    logic signed [DW-1:0]  q_src, q_half;

    assign even_en = smp_vld && (st_q.ph == PH_EVEN);
    assign odd_en  = smp_vld && (st_q.ph == PH_ODD);

    qhb_coef_bank #(.NTAP(NTAP), .CW(CW)) u_coef (
        .clk(clk), .rst(rst), .we(tap_we), .addr(tap_addr),
        .wdata(tap_data), .coef_flat(coef_flat)
    );

    // even samples feed the filter branch: tap k holds x[2m-2k]
    qhb_delay_line #(.DEPTH(NTAP), .DW(DW)) u_even (
        .clk(clk), .rst(rst), .shift_en(even_en),
        .din(smp_data), .taps_flat(even_flat)
    );

    // odd samples feed the centre-tap delay: tap j holds x[2m-1-2j]
    qhb_delay_line #(.DEPTH(HALF), .DW(DW)) u_odd (
        .clk(clk), .rst(rst), .shift_en(odd_en),
        .din(smp_data), .taps_flat(odd_flat)
    );

    qhb_even_mac #(.NTAP(NTAP), .DW(DW), .CSW(CSW), .AW(AW)) u_mac (
        .smp_flat(even_flat), .coef_flat(coef_flat), .acc(acc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        rnd        = (acc + RND_ADD) >>> FRAC;
        signed_rnd = st_q.neg ? -rnd : rnd;
        q_src      = odd_flat[(HALF-1)*DW +: DW];
        q_half     = q_src >>> 1;

        if (smp_vld) begin
            st_d.ph = (st_q.ph == PH_EVEN) ? PH_ODD : PH_EVEN;
        end

        if (odd_en) begin
            st_d.vld = 1'b1;
            st_d.neg = ~st_q.neg;
            if (signed_rnd > SAT_HI)      st_d.i = SAT_HI[DW-1:0];
            else if (signed_rnd < SAT_LO) st_d.i = SAT_LO[DW-1:0];
            else                          st_d.i = signed_rnd[DW-1:0];
            st_d.q = st_q.neg ? -q_half : q_half;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_EVEN, neg: 1'b0, vld: 1'b0, i: '0, q: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign iq_vld = st_q.vld;
    assign iq_i   = st_q.i;
    assign iq_q   = st_q.q;
endmodule

// File: rtl/qhb_chk.sv
module qhb_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_vld,
    input logic          iq_vld,
    input logic [DW-1:0] iq_i,
    input logic [DW-1:0] iq_q
);
    logic par_q;

    always_ff @(posedge clk) begin
        if (rst)          par_q <= 1'b0;
        else if (smp_vld) par_q <= ~par_q;
    end

    // R1
    pair_output_chk: assert property (@(posedge clk) disable iff (rst)
        iq_vld == ($past(smp_vld) && $past(par_q)));

    // R1
    output_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        iq_vld |=> !iq_vld);

    // R4
    q_range_chk: assert property (@(posedge clk) disable iff (rst)
        iq_vld |-> ($signed(iq_q) >= -(2 ** (DW-2)) && $signed(iq_q) <= 2 ** (DW-2)));

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!iq_vld && iq_i == '0 && iq_q == '0));

    // R8
    output_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !iq_vld |-> ($stable(iq_i) && $stable(iq_q)));
endmodule

bind qr_halfband_decim qhb_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .iq_vld(iq_vld), .iq_i(iq_i), .iq_q(iq_q)
);

// File: tb/qr_halfband_decim_tb.sv
module qr_halfband_decim_tb;
    localparam int NTAP = 19;
    localparam int DW   = 16;
    localparam int CW   = 18;
    localparam int TAW  = $clog2(NTAP);
    localparam int QDLY = 2 * (NTAP / 2) - 1;

    logic           clk = 1'b0;
    logic           rst;
    logic           smp_vld;
    logic [DW-1:0]  smp_data;
    logic           tap_we;
    logic [TAW-1:0] tap_addr;
    logic [CW-1:0]  tap_data;
    logic           iq_vld;
    logic [DW-1:0]  iq_i, iq_q;

    always #5 clk = ~clk;

    qr_halfband_decim #(.NTAP(NTAP), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .tap_we(tap_we), .tap_addr(tap_addr), .tap_data(tap_data),
        .iq_vld(iq_vld), .iq_i(iq_i), .iq_q(iq_q)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    n_out = 0;
    int    n_exp = 0;
    bit    done  = 0;
    string i_tag = "R2";
    int    hist[$];
    int    ceff[NTAP];
    int    exp_i_q[$];
    int    exp_q_q[$];

    function automatic int sat(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int model_i(int m);
        longint acc = 0;
        longint r;
        for (int k = 0; k < NTAP; k++) begin
            int n = 2 * m - 2 * k;
            if (n >= 0) acc += longint'(ceff[k]) * longint'(hist[n]);
        end
        r = (acc + 65536) >>> 17;
        if (m % 2 == 1) r = -r;
        return sat(r);
    endfunction

    function automatic int model_q(int m);
        int n = 2 * m - QDLY;
        int v = (n >= 0) ? (hist[n] >>> 1) : 0;
        return (m % 2 == 1) ? -v : v;
    endfunction

    task automatic check(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b0; tap_we = 1'b0;
        smp_data = '0; tap_addr = '0; tap_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hist.delete();
        exp_i_q.delete();
        exp_q_q.delete();
        for (int k = 0; k < NTAP; k++) ceff[k] = 0;
        @(negedge clk);
        // R7: quiet outputs after reset
        check("R7 valid after reset", int'(iq_vld), 0);
        check("R7 I after reset", int'($signed(iq_i)), 0);
        check("R7 Q after reset", int'($signed(iq_q)), 0);
    endtask

    // R3: bench applies the alternate negation itself
    task automatic load_tap(int k, int v);
        @(negedge clk);
        tap_we = 1'b1; tap_addr = TAW'(k); tap_data = CW'(v);
        @(negedge clk);
        tap_we = 1'b0;
        if (k < NTAP) ceff[k] = (k % 2 == 1) ? -v : v;
    endtask

    task automatic push(int x, int gap);
        @(negedge clk);
        smp_vld = 1'b1; smp_data = DW'(x);
        hist.push_back(x);
        if (hist.size() % 2 == 0) begin
            int m = hist.size() / 2 - 1;
            exp_i_q.push_back(model_i(m));
            exp_q_q.push_back(model_q(m));
            n_exp++;
        end
        if (gap > 0) begin
            @(negedge clk);
            smp_vld = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && iq_vld) begin
            n_out++;
            if (exp_i_q.size() == 0) begin
                check("R1 output with no pending pair", 1, 0);
            end else begin
                check(i_tag, int'($signed(iq_i)), exp_i_q.pop_front());
                check("R4 Q", int'($signed(iq_q)), exp_q_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2 R5: impulse on an even sample shows each tap with its sign
        i_tag = "R2 impulse I";
        for (int k = 0; k < NTAP; k++) load_tap(k, 3000 * (k + 1) + 777);
        load_tap(NTAP + 3, 99999);   // R3: out-of-range address ignored
        push(20000, 0);
        for (int j = 0; j < 45; j++) push(0, 0);
        idle(3);

        // R4: impulse on an odd sample shows the centre delay
        push(0, 0);
        push(-31001, 1);
        for (int j = 0; j < 24; j++) push(0, 0);
        idle(3);

        // R8: random data with random idle gaps
        i_tag = "R8 random I";
        for (int k = 0; k < NTAP; k++) load_tap(k, $urandom_range(0, 262143) - 131072);
        for (int j = 0; j < 300; j++) push($urandom_range(0, 65535) - 32768, $urandom_range(0, 3));
        idle(3);

        // R6: saturation in both directions, after the sign toggle
        i_tag = "R6 saturate I";
        for (int k = 0; k < NTAP; k++) load_tap(k, (k % 2 == 1) ? -131072 : 131071);
        for (int j = 0; j < 40; j++) push(32767, 0);
        for (int j = 0; j < 40; j++) push(-32768, 0);
        idle(3);

        // R3: odd tap holding the most negative value keeps full range
        i_tag = "R3 full-range tap I";
        for (int k = 0; k < NTAP; k++) load_tap(k, 0);
        load_tap(1, -131072);
        load_tap(2, 65536);
        for (int j = 0; j < 12; j++) push(((j % 4) - 2) * 9000, 0);
        idle(3);

        // R5 R7: reset mid-stream restarts the sign at positive
        push(1234, 0);
        do_reset();
        i_tag = "R5 restart I";
        load_tap(0, 131071);
        for (int j = 0; j < 20; j++) push(30000, 1);
        idle(3);

        // R1: one output per pair, nothing left over
        check("R1 output count", n_out, n_exp);
        check("R1 leftover expected", exp_i_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule